// File: doc/BRIEF.md
# DSP Address Generator

This block produces data-memory addresses for tight signal-processing loops such as FIR delay lines and FFT passes. It keeps a bank of pointer entries. Each entry has an address, a step and a buffer-size exponent. A command names one entry and an operation. In the same cycle the block puts that entry's current address on the memory port. At the next clock edge it writes the post-modified value back into the entry.

The operations cover several cases. Linear moves are by one or by the step. Circular moves use the same deltas but keep the pointer inside a power-of-two buffer by masking, so the bits above the buffer never move. A bit-reversed step carries from the top of the buffer field downward, which walks an FFT's scrambled order. A step-increment operation changes the step and leaves the address alone.

A separate load port writes any field of any entry, and a combinational read port returns any field. The load port wins over a post-modification of the same field in the same cycle.

Top module: `dsp_addr_gen`

## Requirements
- R1: After reset every address, step and size field of every entry reads zero, and `mem_en` is low while no command is given.
- R2: In the cycle a command is presented, `mem_en` equals `cmd_valid` and `mem_addr` shows the selected entry's address as it was before this command's modification. The new value is visible from the next cycle.
- R3: Operation codes 1 (+1), 2 (−1), 3 (+step) and 4 (−step) update the address modulo 2^AW.
- R4: Operation codes 5 (+1), 6 (−1), 7 (+step) and 8 (−step) are circular, with k being the entry's size field. Only the low k address bits take the new value and the upper bits stay unchanged. A pointer at the top of the buffer that is advanced by one goes to the buffer base, and a pointer at the base that is moved back by one goes to the top.
- R5: Operation code 9 adds the step to the low k address bits with the carry running from bit k−1 toward bit 0. Any carry out of bit 0 is dropped, and the bits above k are held.
- R6: Operation code 10 increments the entry's step by one (modulo 2^AW), keeps the address, and still issues the address on `mem_addr`.
- R7: Operation code 0 and the unused codes 11 to 15 issue the address and change no field.
- R8: A load with `ld_field` 0 writes the address, 1 writes the step, and 2 writes the size from the low bits of `ld_data`. Field code 3 writes nothing.
- R9: When a load and a command modify the same field of the same entry in one cycle, the loaded value is kept.
- R10: `rd_data` combinationally returns the field of entry `rd_sel` chosen by `rd_field` (0 address, 1 step, 2 size zero-extended). Code 3 returns zero.
- R11: A size value above AW behaves as AW, so the circular and bit-reversed operations then span the whole address.
- R12: A command changes only the selected entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Operation code |
| cmd_sel | input | $clog2(NREG) | Entry the command uses |
| ld_valid | input | 1 | Load present this cycle |
| ld_field | input | 2 | Field to load (0 address, 1 step, 2 size, 3 none) |
| ld_sel | input | $clog2(NREG) | Entry to load |
| ld_data | input | AW | Load value |
| rd_sel | input | $clog2(NREG) | Entry to read |
| rd_field | input | 2 | Field to read |
| rd_data | output | AW | Read value |
| mem_en | output | 1 | Memory access strobe |
| mem_addr | output | AW | Address issued to memory |

## Verification
The bench builds the block with AW = 8 and eight entries. The 256-word space makes linear wrap past 255 and below 0 reachable in a few commands. With AW = 8 the size field is 4 bits wide, so sizes 9 to 15 exercise the clamp of R11. Buffers of 4 and 8 words let the circular wrap at both ends and the full bit-reversed visiting order show up within a handful of commands. A random phase mixes loads, reads and every operation code across all entries, including loads and commands that collide on the same entry.

// File: rtl/adg_pkg.sv
package adg_pkg;

    typedef enum logic [3:0] {
        OP_HOLD    = 4'd0,
        OP_INC     = 4'd1,
        OP_DEC     = 4'd2,
        OP_ADDS    = 4'd3,
        OP_SUBS    = 4'd4,
        OP_CINC    = 4'd5,
        OP_CDEC    = 4'd6,
        OP_CADDS   = 4'd7,
        OP_CSUBS   = 4'd8,
        OP_BREV    = 4'd9,
        OP_STEPINC = 4'd10
    } adg_op_e;

    typedef enum logic [1:0] {
        FLD_ADDR = 2'd0,
        FLD_STEP = 2'd1,
        FLD_SIZE = 2'd2,
        FLD_NONE = 2'd3
    } adg_field_e;

endpackage

// File: rtl/adg_modify.sv
module adg_modify
    import adg_pkg::*;
#(
    parameter int AW = 16,
    parameter int KW = $clog2(AW + 1)
) (
    input  adg_op_e         op,
    input  logic [AW-1:0]   cur_a,
    input  logic [AW-1:0]   cur_s,
    input  logic [KW-1:0]   size_k,
    output logic [AW-1:0]   nxt_a,
    output logic [AW-1:0]   nxt_s,
    output logic            a_we,
    output logic            s_we,
    output logic [AW-1:0]   buf_mask
);
    localparam int IW = (AW > 1) ? $clog2(AW) : 1;

    logic [KW-1:0] k_eff;
    logic [AW-1:0] one_v;
    logic [AW-1:0] lin_p1, lin_m1, lin_ps, lin_ms;
    logic [AW-1:0] rev_a, rev_s, rev_sum, brev_a;

    // Reverse the low k bits of x; bits at or above k become zero.
    function automatic logic [AW-1:0] rev_field(input logic [AW-1:0] x, input int k);
        logic [AW-1:0] r;
        r = '0;
        for (int i = 0; i < AW; i++) begin
            if (i < k) r[i] = x[IW'(k - 1 - i)];
        end
        return r;
    endfunction

    // Clamp the size exponent to the address width (R11).
    assign k_eff = (size_k > KW'(AW)) ? KW'(AW) : size_k;

    always_comb begin
        buf_mask = '0;
        for (int i = 0; i < AW; i++) begin
            buf_mask[i] = (i < int'(k_eff));
        end
    end

    assign one_v  = AW'(1);
    assign lin_p1 = cur_a + one_v;
    assign lin_m1 = cur_a - one_v;
    assign lin_ps = cur_a + cur_s;
    assign lin_ms = cur_a - cur_s;

    // Bit-reversed add: reverse, add, reverse back within the field (R5).
    assign rev_a   = rev_field(cur_a, int'(k_eff));
    assign rev_s   = rev_field(cur_s, int'(k_eff));
    assign rev_sum = rev_field(rev_a + rev_s, int'(k_eff));
    assign brev_a  = (cur_a & ~buf_mask) | (rev_sum & buf_mask);

    always_comb begin
        nxt_a = cur_a;
        nxt_s = cur_s;
        a_we  = 1'b0;
        s_we  = 1'b0;
        unique case (op)
            OP_INC:     begin nxt_a = lin_p1; a_we = 1'b1; end
            OP_DEC:     begin nxt_a = lin_m1; a_we = 1'b1; end
            OP_ADDS:    begin nxt_a = lin_ps; a_we = 1'b1; end
            OP_SUBS:    begin nxt_a = lin_ms; a_we = 1'b1; end
            OP_CINC:    begin nxt_a = (cur_a & ~buf_mask) | (lin_p1 & buf_mask); a_we = 1'b1; end
            OP_CDEC:    begin nxt_a = (cur_a & ~buf_mask) | (lin_m1 & buf_mask); a_we = 1'b1; end
            OP_CADDS:   begin nxt_a = (cur_a & ~buf_mask) | (lin_ps & buf_mask); a_we = 1'b1; end
            OP_CSUBS:   begin nxt_a = (cur_a & ~buf_mask) | (lin_ms & buf_mask); a_we = 1'b1; end
            OP_BREV:    begin nxt_a = brev_a; a_we = 1'b1; end
            OP_STEPINC: begin nxt_s = cur_s + one_v; s_we = 1'b1; end
            default:    begin end
        endcase
    end

endmodule

// File: rtl/adg_regbank.sv
module adg_regbank
    import adg_pkg::*;
#(
    parameter int AW   = 16,
    parameter int NREG = 8,
    parameter int KW   = $clog2(AW + 1),
    parameter int SW   = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mod_valid,
    input  logic [SW-1:0]     mod_sel,
    input  logic              a_we,
    input  logic              s_we,
    input  logic [AW-1:0]     nxt_a,
    input  logic [AW-1:0]     nxt_s,
    input  logic              ld_valid,
    input  adg_field_e        ld_field,
    input  logic [SW-1:0]     ld_sel,
    input  logic [AW-1:0]     ld_data,
    output logic [AW-1:0]     addr_q [NREG],
    output logic [AW-1:0]     step_q [NREG],
    output logic [KW-1:0]     size_q [NREG]
);
    for (genvar g = 0; g < NREG; g++) begin : g_entry
        logic hit_mod, hit_ld;
        assign hit_mod = mod_valid && (mod_sel == SW'(g));
        assign hit_ld  = ld_valid  && (ld_sel  == SW'(g));

        // Load beats post-modification on the same field (R9).
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                addr_q[g] <= '0;
                step_q[g] <= '0;
                size_q[g] <= '0;
            end else begin
                if (hit_ld && ld_field == FLD_ADDR)  addr_q[g] <= ld_data;
                else if (hit_mod && a_we)            addr_q[g] <= nxt_a;

                if (hit_ld && ld_field == FLD_STEP)  step_q[g] <= ld_data;
                else if (hit_mod && s_we)            step_q[g] <= nxt_s;

                if (hit_ld && ld_field == FLD_SIZE)  size_q[g] <= ld_data[KW-1:0];
            end
        end
    end

endmodule

// File: rtl/dsp_addr_gen.sv
module dsp_addr_gen
    import adg_pkg::*;
#(
    parameter int AW   = 16,
    parameter int NREG = 8,
    localparam int KW  = $clog2(AW + 1),
    localparam int SW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic [3:0]     cmd_op,
    input  logic [SW-1:0]  cmd_sel,
    input  logic           ld_valid,
    input  logic [1:0]     ld_field,
    input  logic [SW-1:0]  ld_sel,
    input  logic [AW-1:0]  ld_data,
    input  logic [SW-1:0]  rd_sel,
    input  logic [1:0]     rd_field,
    output logic [AW-1:0]  rd_data,
    output logic           mem_en,
    output logic [AW-1:0]  mem_addr
);
    adg_op_e       op_e;
    adg_field_e    ld_f, rd_f;
    logic [AW-1:0] addr_q [NREG];
    logic [AW-1:0] step_q [NREG];
    logic [KW-1:0] size_q [NREG];
    logic [AW-1:0] cur_addr, cur_step, nxt_a, nxt_s, cur_mask;
    logic [KW-1:0] cur_size;
    logic          a_we, s_we;
    logic          ld_hit_addr, is_circ;

    assign op_e = adg_op_e'(cmd_op);
    assign ld_f = adg_field_e'(ld_field);
    assign rd_f = adg_field_e'(rd_field);

    assign cur_addr = addr_q[cmd_sel];
    assign cur_step = step_q[cmd_sel];
    assign cur_size = size_q[cmd_sel];

    // Address goes out before the update (R2).
    assign mem_en   = cmd_valid;
    assign mem_addr = cur_addr;

    adg_modify #(.AW(AW), .KW(KW)) u_modify (
        .op       (op_e),
        .cur_a    (cur_addr),
        .cur_s    (cur_step),
        .size_k   (cur_size),
        .nxt_a    (nxt_a),
        .nxt_s    (nxt_s),
        .a_we     (a_we),
        .s_we     (s_we),
        .buf_mask (cur_mask)
    );

    adg_regbank #(.AW(AW), .NREG(NREG), .KW(KW), .SW(SW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .mod_valid (cmd_valid),
        .mod_sel   (cmd_sel),
        .a_we      (a_we),
        .s_we      (s_we),
        .nxt_a     (nxt_a),
        .nxt_s     (nxt_s),
        .ld_valid  (ld_valid),
        .ld_field  (ld_f),
        .ld_sel    (ld_sel),
        .ld_data   (ld_data),
        .addr_q    (addr_q),
        .step_q    (step_q),
        .size_q    (size_q)
    );

    // Read port (R10).
    always_comb begin
        unique case (rd_f)
            FLD_ADDR: rd_data = addr_q[rd_sel];
            FLD_STEP: rd_data = step_q[rd_sel];
            FLD_SIZE: rd_data = AW'(size_q[rd_sel]);
            default:  rd_data = '0;
        endcase
    end

    assign ld_hit_addr = ld_valid && (ld_f == FLD_ADDR) && (ld_sel == cmd_sel);
    assign is_circ     = (op_e == OP_CINC) || (op_e == OP_CDEC) ||
                         (op_e == OP_CADDS) || (op_e == OP_CSUBS);

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_f == FLD_ADDR) |=> (addr_q[$past(ld_sel)] == $past(ld_data))); // R9

    AST_INC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op_e == OP_INC && !ld_hit_addr)
            |=> (addr_q[$past(cmd_sel)] == $past(cur_addr) + AW'(1))); // R3

    AST_CIRC_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && is_circ && !ld_hit_addr)
            |=> ((addr_q[$past(cmd_sel)] & ~$past(cur_mask)) ==
                 ($past(cur_addr) & ~$past(cur_mask)))); // R4

    AST_STEPINC_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op_e == OP_STEPINC && !ld_hit_addr)
            |=> (addr_q[$past(cmd_sel)] == $past(cur_addr))); // R6

    AST_HOLD_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op_e == OP_HOLD && !ld_valid)
            |=> (addr_q[$past(cmd_sel)] == $past(cur_addr)) &&
                (step_q[$past(cmd_sel)] == $past(cur_step))); // R7

endmodule

// File: tb/dsp_addr_gen_tb_top.sv
module dsp_addr_gen_tb_top;
    localparam int AW   = 8;
    localparam int NREG = 8;
    localparam int FULL = (1 << AW) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_op = '0;
    logic [2:0] cmd_sel = '0;
    logic       ld_valid = 1'b0;
    logic [1:0] ld_field = '0;
    logic [2:0] ld_sel = '0;
    logic [7:0] ld_data = '0;
    logic [2:0] rd_sel = '0;
    logic [1:0] rd_field = '0;
    logic [7:0] rd_data;
    logic       mem_en;
    logic [7:0] mem_addr;

    int errors = 0;
    int checks = 0;
    int m_a [NREG];
    int m_s [NREG];
    int m_k [NREG];

    always #5 clk = ~clk;

    dsp_addr_gen #(.AW(AW), .NREG(NREG)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_sel(cmd_sel), .ld_valid(ld_valid), .ld_field(ld_field),
        .ld_sel(ld_sel), .ld_data(ld_data), .rd_sel(rd_sel),
        .rd_field(rd_field), .rd_data(rd_data), .mem_en(mem_en),
        .mem_addr(mem_addr)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    function automatic int keff(input int k);
        return (k > AW) ? AW : k;
    endfunction

    // Reference: next address after an operation.
    function automatic int ref_next(input int op, input int a, input int s, input int kraw);
        int k, m, r, c, t;
        k = keff(kraw);
        m = (1 << k) - 1;
        case (op)
            1: return (a + 1) & FULL;
            2: return (a - 1) & FULL;
            3: return (a + s) & FULL;
            4: return (a - s) & FULL;
            5: return (a & ~m & FULL) | ((a + 1) & m);
            6: return (a & ~m & FULL) | ((a - 1) & m);
            7: return (a & ~m & FULL) | ((a + s) & m);
            8: return (a & ~m & FULL) | ((a - s) & m);
            9: begin
                r = a; c = 0;
                for (int b = k - 1; b >= 0; b--) begin
                    t = ((a >> b) & 1) + ((s >> b) & 1) + c;
                    r = (r & ~(1 << b)) | ((t & 1) << b);
                    c = t >> 1;
                end
                return r;
            end
            default: return a;
        endcase
    endfunction

    function automatic int ref_rd(input int sel, input int f);
        case (f)
            0: return m_a[sel];
            1: return m_s[sel];
            2: return m_k[sel];
            default: return 0;
        endcase
    endfunction

    task automatic step(input string tag, input int cv, input int op, input int sel,
                        input int lv, input int lf, input int lsel, input int ld,
                        input int rsel, input int rf, input int lit);
        @(negedge clk);
        cmd_valid = cv[0];
        cmd_op    = 4'(op);
        cmd_sel   = 3'(sel);
        ld_valid  = lv[0];
        ld_field  = 2'(lf);
        ld_sel    = 3'(lsel);
        ld_data   = 8'(ld);
        rd_sel    = 3'(rsel);
        rd_field  = 2'(rf);
        #1;
        chk({tag, " R2 mem_en"}, int'(mem_en), cv);
        if (cv != 0) chk({tag, " R2 mem_addr"}, int'(mem_addr), m_a[sel]);
        if (lit >= 0) chk({tag, " literal mem_addr"}, int'(mem_addr), lit);
        chk({tag, " R10 rd_data"}, int'(rd_data), ref_rd(rsel, rf));
        @(posedge clk);
        if (cv != 0) begin
            if (op == 10) m_s[sel] = (m_s[sel] + 1) & FULL;
            else m_a[sel] = ref_next(op, m_a[sel], m_s[sel], m_k[sel]);
        end
        if (lv != 0) begin
            case (lf)
                0: m_a[lsel] = ld & FULL;
                1: m_s[lsel] = ld & FULL;
                2: m_k[lsel] = ld & 15;
                default: ;
            endcase
        end
    endtask

    task automatic cmd(input string tag, input int op, input int sel, input int lit);
        step(tag, 1, op, sel, 0, 0, 0, 0, sel, 0, lit);
    endtask

    task automatic ld(input string tag, input int sel, input int f, input int d);
        step(tag, 0, 0, 0, 1, f, sel, d, sel, f, -1);
    endtask

    task automatic rd(input string tag, input int sel, input int f, input int lit);
        step(tag, 0, 0, 0, 0, 0, 0, 0, sel, f, -1);
        if (lit >= 0) chk({tag, " literal rd_data"}, int'(rd_data), lit);
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) begin m_a[i] = 0; m_s[i] = 0; m_k[i] = 0; end
        repeat (3) @(posedge clk);
        #1;
        chk("R1 mem_en in reset", int'(mem_en), 0);
        @(negedge clk) rst_n = 1'b1;
        // R1: all fields zero after reset
        for (int i = 0; i < NREG; i++)
            for (int f = 0; f < 3; f++) rd("R1 reset field", i, f, 0);

        // R8: loads of each field, field code 3 ignored
        ld("R8 load addr", 0, 0, 8'h10);
        ld("R8 load step", 0, 1, 3);
        ld("R8 load size", 0, 2, 2);
        ld("R8 field3 ignored", 0, 3, 8'hEE);
        rd("R8 addr after field3", 0, 0, 8'h10);
        rd("R10 field3 reads zero", 0, 3, 0);

        // R2/R3: linear moves
        cmd("R3 inc", 1, 0, 8'h10);
        cmd("R3 adds", 3, 0, 8'h11);
        cmd("R3 subs", 4, 0, 8'h14);
        cmd("R3 dec", 2, 0, 8'h11);
        rd("R3 after dec", 0, 0, 8'h10);
        ld("R3 addr ff", 3, 0, 8'hFF);
        cmd("R3 inc wraps", 1, 3, 8'hFF);
        cmd("R3 dec wraps", 2, 3, 8'h00);
        rd("R3 back at ff", 3, 0, 8'hFF);

        // R4: circular buffer of 4 at 0x10
        ld("R4 top", 0, 0, 8'h13);
        cmd("R4 cinc at top", 5, 0, 8'h13);
        cmd("R4 cdec at base", 6, 0, 8'h10);
        cmd("R4 cadds", 7, 0, 8'h13);
        cmd("R4 csubs", 8, 0, 8'h12);
        rd("R4 after csubs", 0, 0, 8'h13);

        // R5: bit-reversed order over 8 entries
        ld("R5 base", 2, 0, 8'h20);
        ld("R5 step", 2, 1, 4);
        ld("R5 size", 2, 2, 3);
        cmd("R5 brev 0", 9, 2, 8'h20);
        cmd("R5 brev 1", 9, 2, 8'h24);
        cmd("R5 brev 2", 9, 2, 8'h22);
        cmd("R5 brev 3", 9, 2, 8'h26);
        cmd("R5 brev 4", 9, 2, 8'h21);

        // R6: step increment keeps address
        cmd("R6 stepinc", 10, 2, 8'h25);
        rd("R6 step now 5", 2, 1, 5);
        rd("R6 addr held", 2, 0, 8'h25);

        // R7: hold and unused codes
        cmd("R7 hold", 0, 2, 8'h25);
        cmd("R7 code 15", 15, 2, 8'h25);
        cmd("R7 code 11", 11, 2, 8'h25);
        rd("R7 addr unchanged", 2, 0, 8'h25);
        rd("R7 step unchanged", 2, 1, 5);

        // R9: load beats command on the same field
        step("R9 collide addr", 1, 1, 0, 1, 0, 0, 8'h40, 0, 0, -1);
        rd("R9 load kept", 0, 0, 8'h40);
        step("R9 collide step", 1, 10, 2, 1, 1, 2, 8'h09, 2, 1, -1);
        rd("R9 step load kept", 2, 1, 9);

        // R11: size above AW clamps
        ld("R11 size 12", 3, 2, 12);
        cmd("R11 cinc full span", 5, 3, 8'hFF);
        rd("R11 wrapped to 0", 3, 0, 0);

        // R12: other entries untouched
        rd("R12 entry5 addr", 5, 0, 0);
        rd("R12 entry5 step", 5, 1, 0);

        // Random mix of everything
        for (int n = 0; n < 3000; n++) begin
            step("R12 random", int'($urandom_range(0, 1)), int'($urandom_range(0, 15)),
                 int'($urandom_range(0, 7)), int'($urandom_range(0, 3) == 0),
                 int'($urandom_range(0, 3)), int'($urandom_range(0, 7)),
                 int'($urandom_range(0, 255)), int'($urandom_range(0, 7)),
                 int'($urandom_range(0, 3)), -1);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule